// File: doc/BRIEF.md
# Dual-Mode Stopwatch Mode Controller

This block is the control state machine of a two-function stopwatch. One function counts up from zero. The other counts down from a duration that the user sets. The block receives one-cycle press pulses for three buttons: Mode, Action and Stopgo. It moves between two menu levels. At the outer level the user picks a function. At the inner level the chosen timer is ready, running or paused. From its state the block drives five indicator lamps and a set of commands to a separate timer datapath: clear, run, increment the set duration, and count direction. The datapath returns a flag that says the down count has reached zero. On that flag the controller stops the timer by itself.

The eight states are one-hot:

| State | Meaning |
|---|---|
| UP_WAIT | The outer level, with the up function chosen |
| UP_READY | The up timer, cleared and ready |
| UP_RUN | The up timer, counting |
| UP_PAUSE | The up timer, held |
| DN_WAIT | The outer level, with the down function chosen |
| DN_READY | The down timer, cleared, while the duration is set |
| DN_RUN | The down timer, counting |
| DN_PAUSE | The down timer, held or stopped at zero |

The transitions are:

| Transition | Effect |
|---|---|
| toggle | Mode in UP_WAIT or DN_WAIT swaps the two waits. |
| enter | Action in a wait state moves to the ready state of that function. |
| exit | Mode in ready, run or pause returns to the wait state of the same function. |
| rearm | Action in run or pause returns to ready. |
| start | Stopgo in ready moves to run. |
| hold | Stopgo in run moves to pause. |
| resume | Stopgo in pause moves to run. |
| autostop | The zero flag in DN_RUN moves to DN_PAUSE. |
| bump | Action in DN_READY stays in DN_READY and issues one increment. |

Top module: `stopwatch_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the block is in UP_WAIT. In UP_WAIT `led_up`=1 and `tmr_clear`=1, and every other output is 0. Asserting `rst_n` low in any state returns the block to UP_WAIT.
- R2: In a wait state, a Mode press swaps UP_WAIT and DN_WAIT (toggle). An Action press moves to the ready state of the chosen function (enter).
- R3: In a ready, run or pause state, a Mode press returns to the wait state of the same function (exit).
- R4: In a run or pause state, an Action press moves to the ready state of that function (rearm). On a rearm, `tmr_clear` is 1 for exactly the first cycle in ready. `tmr_clear` is also held at 1 in both wait states.
- R5: A Stopgo press moves ready to run (start), run to pause (hold) and pause to run (resume).
- R6: In DN_READY, each Action press raises `tmr_inc` for exactly one cycle and leaves the state unchanged (bump). In UP_READY, an Action press has no effect on any output.
- R7: `led_up` is 1 in the four UP states and `led_down` is 1 in the four DN states. `led_chosen` is 1 in the ready, run and pause states. `led_running` is 1 in the run states and `led_halted` is 1 in the pause states. `tmr_run` equals `led_running`, and `tmr_down` equals `led_down`.
- R8: In DN_RUN, `tmr_zero`=1 with no Mode or Action press moves to DN_PAUSE (autostop). `tmr_zero` has no effect in any other state.
- R9: A press that the transition table does not list for the current state has no effect on any output. Examples are Stopgo in a wait state and Action in UP_READY.
- R10: When several presses arrive in one cycle, only one is acted on. Mode has the highest priority, then Action, then Stopgo.
- R11: Every transition and every `tmr_inc` pulse appears in the first cycle after the clock edge that sampled the press. The lamps decode the state directly, with no further register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| press_mode | input | 1 | One-cycle Mode press pulse |
| press_action | input | 1 | One-cycle Action press pulse |
| press_stopgo | input | 1 | One-cycle Stopgo press pulse |
| tmr_zero | input | 1 | The datapath reports that the count has reached zero |
| led_up | output | 1 | Lamp: the up function is chosen |
| led_down | output | 1 | Lamp: the down function is chosen |
| led_chosen | output | 1 | Lamp: a function has been entered |
| led_running | output | 1 | Lamp: the timer is counting |
| led_halted | output | 1 | Lamp: the timer is paused or stopped |
| tmr_clear | output | 1 | Command: hold the timer value at zero |
| tmr_run | output | 1 | Command: the timer counts |
| tmr_inc | output | 1 | Command: add one step to the set duration (a one-cycle pulse) |
| tmr_down | output | 1 | Command: the count direction is down |

## Verification
All outputs change in the cycle after the edge that samples a press or the zero flag. The lamps and the direction output decode the state directly, and the clear and increment pulses come from registers at that same edge, so no result is due later than one cycle. Only the one-cycle pulses from a rearm or a bump fall back to zero one cycle after that. The driver raises the inputs on a falling edge and pushes the expected outputs into the queue just after the next rising edge. The monitor pops and compares on the following falling edge, so it checks each stimulus exactly one cycle after it was sampled. A reset applied mid-run is checked a short time after `rst_n` falls, without waiting for a clock.

// File: rtl/swc_pkg.sv
package swc_pkg;

    localparam int N_BTN      = 3;
    localparam int BTN_MODE   = 0;
    localparam int BTN_ACTION = 1;
    localparam int BTN_STOPGO = 2;

    localparam int N_STATE = 8;

    typedef enum logic [N_STATE-1:0] {
        S_UP_WAIT  = 8'b0000_0001,
        S_UP_READY = 8'b0000_0010,
        S_UP_RUN   = 8'b0000_0100,
        S_UP_PAUSE = 8'b0000_1000,
        S_DN_WAIT  = 8'b0001_0000,
        S_DN_READY = 8'b0010_0000,
        S_DN_RUN   = 8'b0100_0000,
        S_DN_PAUSE = 8'b1000_0000
    } swc_state_t;

endpackage

// File: rtl/swc_press_arb.sv
module swc_press_arb #(
    parameter int N_REQ = 3
) (
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] grant
);

    genvar gi;
    generate
        for (gi = 0; gi < N_REQ; gi++) begin : g_lane
            if (gi == 0) begin : g_top
                assign grant[gi] = req[gi];
            end else begin : g_low
                assign grant[gi] = req[gi] & ~(|req[gi-1:0]);
            end
        end
    endgenerate

endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
    import swc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_BTN-1:0] grant,
    input  logic             zero_seen,
    output swc_state_t       state_q
);

    swc_state_t state_d;

    logic go_mode;
    logic go_action;
    logic go_stopgo;

    assign go_mode   = grant[BTN_MODE];
    assign go_action = grant[BTN_ACTION];
    assign go_stopgo = grant[BTN_STOPGO];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_UP_WAIT: begin
                if (go_mode)        state_d = S_DN_WAIT;
                else if (go_action) state_d = S_UP_READY;
            end
            S_UP_READY: begin
                if (go_mode)        state_d = S_UP_WAIT;
                else if (go_stopgo) state_d = S_UP_RUN;
            end
            S_UP_RUN: begin
                if (go_mode)        state_d = S_UP_WAIT;
                else if (go_action) state_d = S_UP_READY;
                else if (go_stopgo) state_d = S_UP_PAUSE;
            end
            S_UP_PAUSE: begin
                if (go_mode)        state_d = S_UP_WAIT;
                else if (go_action) state_d = S_UP_READY;
                else if (go_stopgo) state_d = S_UP_RUN;
            end
            S_DN_WAIT: begin
                if (go_mode)        state_d = S_UP_WAIT;
                else if (go_action) state_d = S_DN_READY;
            end
            S_DN_READY: begin
                if (go_mode)        state_d = S_DN_WAIT;
                else if (go_stopgo) state_d = S_DN_RUN;
            end
            S_DN_RUN: begin
                if (go_mode)        state_d = S_DN_WAIT;
                else if (go_action) state_d = S_DN_READY;
                else if (go_stopgo) state_d = S_DN_PAUSE;
                else if (zero_seen) state_d = S_DN_PAUSE;
            end
            S_DN_PAUSE: begin
                if (go_mode)        state_d = S_DN_WAIT;
                else if (go_action) state_d = S_DN_READY;
                else if (go_stopgo) state_d = S_DN_RUN;
            end
            default: state_d = S_UP_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_UP_WAIT;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/swc_out_dec.sv
module swc_out_dec
    import swc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  swc_state_t       state_q,
    input  logic [N_BTN-1:0] grant,
    output logic             led_up,
    output logic             led_down,
    output logic             led_chosen,
    output logic             led_running,
    output logic             led_halted,
    output logic             tmr_clear,
    output logic             tmr_run,
    output logic             tmr_inc,
    output logic             tmr_down
);

    logic in_wait;
    logic in_run;
    logic in_pause;
    logic in_dn;
    logic rearm_hit;
    logic bump_hit;
    logic clr_pulse_q;
    logic inc_pulse_q;

    always_comb begin
        in_wait  = (state_q == S_UP_WAIT)  || (state_q == S_DN_WAIT);
        in_run   = (state_q == S_UP_RUN)   || (state_q == S_DN_RUN);
        in_pause = (state_q == S_UP_PAUSE) || (state_q == S_DN_PAUSE);
        in_dn    = (state_q == S_DN_WAIT)  || (state_q == S_DN_READY) ||
                   (state_q == S_DN_RUN)   || (state_q == S_DN_PAUSE);
    end

    always_comb begin
        rearm_hit = grant[BTN_ACTION] && (in_run || in_pause);
        bump_hit  = grant[BTN_ACTION] && (state_q == S_DN_READY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_pulse_q <= 1'b0;
            inc_pulse_q <= 1'b0;
        end else begin
            clr_pulse_q <= rearm_hit;
            inc_pulse_q <= bump_hit;
        end
    end

    always_comb begin
        led_up      = !in_dn;
        led_down    = in_dn;
        led_chosen  = !in_wait;
        led_running = in_run;
        led_halted  = in_pause;
        tmr_clear   = in_wait || clr_pulse_q;
        tmr_run     = in_run;
        tmr_inc     = inc_pulse_q;
        tmr_down    = in_dn;
    end

endmodule

// File: rtl/stopwatch_ctrl.sv
module stopwatch_ctrl
    import swc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic press_mode,
    input  logic press_action,
    input  logic press_stopgo,
    input  logic tmr_zero,
    output logic led_up,
    output logic led_down,
    output logic led_chosen,
    output logic led_running,
    output logic led_halted,
    output logic tmr_clear,
    output logic tmr_run,
    output logic tmr_inc,
    output logic tmr_down
);

    logic [N_BTN-1:0] btn_req;
    logic [N_BTN-1:0] btn_grant;
    swc_state_t       state_q;

    always_comb begin
        btn_req             = '0;
        btn_req[BTN_MODE]   = press_mode;
        btn_req[BTN_ACTION] = press_action;
        btn_req[BTN_STOPGO] = press_stopgo;
    end

    swc_press_arb #(.N_REQ(N_BTN)) u_arb (
        .req   (btn_req),
        .grant (btn_grant)
    );

    swc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (btn_grant),
        .zero_seen (tmr_zero),
        .state_q   (state_q)
    );

    swc_out_dec u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_q     (state_q),
        .grant       (btn_grant),
        .led_up      (led_up),
        .led_down    (led_down),
        .led_chosen  (led_chosen),
        .led_running (led_running),
        .led_halted  (led_halted),
        .tmr_clear   (tmr_clear),
        .tmr_run     (tmr_run),
        .tmr_inc     (tmr_inc),
        .tmr_down    (tmr_down)
    );

endmodule

// File: rtl/stopwatch_ctrl_chk.sv
module stopwatch_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic press_mode,
    input logic press_action,
    input logic press_stopgo,
    input logic tmr_zero,
    input logic led_down,
    input logic led_chosen,
    input logic led_running,
    input logic led_halted,
    input logic tmr_clear,
    input logic tmr_inc
);

    AST_TOGGLE_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!led_chosen && press_mode) |=> (!led_chosen && (led_down != $past(led_down)))); // R2

    AST_EXIT_SAME_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (led_chosen && press_mode) |=> (!led_chosen && (led_down == $past(led_down)))); // R3

    AST_CLEAR_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !led_chosen |-> tmr_clear); // R4

    AST_START_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (led_chosen && !led_running && !led_halted && press_stopgo && !press_mode && !press_action)
        |=> led_running); // R5

    AST_INC_ONLY_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_inc |-> $past(press_action && !press_mode && led_down && led_chosen && !led_running && !led_halted)); // R6

    AST_RUN_HALT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(led_running && led_halted)); // R7

    AST_AUTOSTOP: assert property (@(posedge clk) disable iff (!rst_n)
        (led_down && led_running && tmr_zero && !press_mode && !press_action) |=> (led_halted && !led_running)); // R8

    AST_MODE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (led_chosen && press_mode && (press_action || press_stopgo)) |=> !led_chosen); // R10

endmodule

bind stopwatch_ctrl stopwatch_ctrl_chk chk_i (.*);

// File: tb/stopwatch_ctrl_tb_top.sv
module stopwatch_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n;
    logic press_mode, press_action, press_stopgo, tmr_zero;
    logic led_up, led_down, led_chosen, led_running, led_halted;
    logic tmr_clear, tmr_run, tmr_inc, tmr_down;

    always #4 clk = ~clk;

    stopwatch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .press_mode(press_mode), .press_action(press_action),
        .press_stopgo(press_stopgo), .tmr_zero(tmr_zero),
        .led_up(led_up), .led_down(led_down), .led_chosen(led_chosen),
        .led_running(led_running), .led_halted(led_halted),
        .tmr_clear(tmr_clear), .tmr_run(tmr_run), .tmr_inc(tmr_inc),
        .tmr_down(tmr_down)
    );

    typedef struct {
        logic [8:0] expv;
        string      tag;
    } sb_item_t;

    sb_item_t sbq[$];
    int checks   = 0;
    int failures = 0;

    // Reference model: mdl_dn selects the function; mdl_lvl 0 wait, 1 ready, 2 run, 3 pause.
    bit mdl_dn  = 1'b0;
    int mdl_lvl = 0;

    function automatic logic [8:0] actual_vec();
        return {led_up, led_down, led_chosen, led_running, led_halted,
                tmr_clear, tmr_run, tmr_inc, tmr_down};
    endfunction

    function automatic logic [8:0] model_vec(bit clrp, bit incp);
        return {!mdl_dn, mdl_dn, (mdl_lvl != 0), (mdl_lvl == 2), (mdl_lvl == 3),
                ((mdl_lvl == 0) || clrp), (mdl_lvl == 2), incp, mdl_dn};
    endfunction

    task automatic check_now(input logic [8:0] expv, input string tag);
        logic [8:0] act;
        act = actual_vec();
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, expv);
        end
    endtask

    task automatic step(input bit m, input bit a, input bit s, input bit z, input string tag);
        bit clrp;
        bit incp;
        sb_item_t it;
        @(negedge clk);
        press_mode = m; press_action = a; press_stopgo = s; tmr_zero = z;
        clrp = 1'b0;
        incp = 1'b0;
        if (m) begin
            if (mdl_lvl == 0) mdl_dn = !mdl_dn;
            else              mdl_lvl = 0;
        end else if (a) begin
            if (mdl_lvl == 0)      mdl_lvl = 1;
            else if (mdl_lvl == 1) incp = mdl_dn;
            else begin
                mdl_lvl = 1;
                clrp = 1'b1;
            end
        end else if (s) begin
            if (mdl_lvl == 1)      mdl_lvl = 2;
            else if (mdl_lvl == 2) mdl_lvl = 3;
            else if (mdl_lvl == 3) mdl_lvl = 2;
        end else if (z && mdl_dn && mdl_lvl == 2) begin
            mdl_lvl = 3;
        end
        @(posedge clk);
        it.expv = model_vec(clrp, incp);
        it.tag  = tag;
        sbq.push_back(it);
    endtask

    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            check_now(it.expv, it.tag);
        end
    end

    task automatic print_summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R11 actual=timeout expected=completion");
        print_summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        press_mode = 1'b0; press_action = 1'b0; press_stopgo = 1'b0; tmr_zero = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now(9'b1_0_0_0_0_1_0_0_0, "R1 state during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_now(9'b1_0_0_0_0_1_0_0_0, "R1 state after release");

        step(0, 0, 1, 0, "R9 stopgo in UP_WAIT ignored");
        step(0, 0, 0, 1, "R8 zero in UP_WAIT ignored");
        step(0, 1, 0, 0, "R2 enter UP_READY");
        step(0, 1, 0, 0, "R6 action in UP_READY no effect");
        step(0, 0, 1, 0, "R5 start UP_RUN");
        step(0, 0, 0, 1, "R8 zero in UP_RUN ignored");
        step(0, 0, 1, 0, "R5 hold UP_PAUSE");
        step(0, 0, 1, 0, "R5 resume UP_RUN");
        step(0, 1, 0, 0, "R4 rearm UP_READY clear pulse");
        step(0, 0, 0, 0, "R4 clear pulse lasts one cycle");
        step(0, 0, 1, 0, "R11 start again");
        step(1, 0, 0, 0, "R3 exit to UP_WAIT");
        step(1, 0, 0, 0, "R2 toggle to DN_WAIT");
        step(1, 0, 0, 0, "R2 toggle to UP_WAIT");
        step(1, 0, 0, 0, "R2 toggle to DN_WAIT again");
        step(0, 0, 1, 0, "R9 stopgo in DN_WAIT ignored");
        step(0, 1, 0, 0, "R2 enter DN_READY");
        step(0, 1, 0, 0, "R6 bump one");
        step(0, 1, 0, 0, "R6 bump two back to back");
        step(0, 0, 0, 0, "R6 inc pulse drops");
        step(0, 0, 0, 1, "R8 zero in DN_READY ignored");
        step(0, 0, 1, 0, "R5 start DN_RUN");
        step(0, 0, 0, 0, "R7 DN_RUN lamps");
        step(0, 0, 0, 1, "R8 autostop to DN_PAUSE");
        step(0, 0, 0, 1, "R8 zero in DN_PAUSE ignored");
        step(0, 0, 1, 0, "R5 resume DN_RUN");
        step(1, 1, 1, 0, "R10 mode wins over action and stopgo");
        step(0, 1, 1, 0, "R10 action wins in DN_WAIT");
        step(0, 0, 1, 0, "R5 start DN_RUN from ready");
        step(0, 1, 1, 0, "R10 action wins over stopgo in run");
        step(0, 0, 1, 1, "R5 start with zero present");
        step(0, 0, 1, 0, "R5 hold DN_PAUSE");
        step(0, 1, 0, 0, "R4 rearm DN_READY from pause");
        step(0, 0, 1, 0, "R3 start before exit");
        step(1, 0, 0, 0, "R3 exit to DN_WAIT");
        step(0, 1, 0, 0, "R2 enter DN_READY before reset");
        step(0, 0, 1, 0, "R5 run before reset");

        @(negedge clk);
        #2 rst_n = 1'b0;
        #1 check_now(9'b1_0_0_0_0_1_0_0_0, "R1 reset from DN_RUN");
        mdl_dn  = 1'b0;
        mdl_lvl = 0;
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 1, 0, 0, "R1 UP function after reset");
        step(0, 0, 0, 0, "R7 idle UP_READY");

        @(negedge clk);
        @(negedge clk);
        #1;
        print_summary();
        $finish;
    end

endmodule